// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to normal operation once its clock is running. A start pulse launches a fixed series of memory commands. When the fast-mode strap is set, the block first waits for the strobe delay-locked loop to report lock. The series ends with a memory-clear phase, and only after that does the block raise a ready flag that lets the regular access scheduler take over. Periodic refresh is switched on as soon as the last mode load completes.

Each command is presented on a command port together with its argument. The command stays asserted, which acts as the busy flag, until the memory interface returns a done pulse. Every wait has a cycle limit: the per-command wait, the memory-clear wait, and the number of lock polls. If any limit runs out, the sequence stops and the block parks in an error state until the next reset. A step code shows which phase is active.

Top module: `sdram_init_seq`

## Requirements
- R1: Under reset and afterwards until start, cmd_valid, refresh_en, clear_req, ready and error are 0 and step is 0 (idle).
- R2: Command order is precharge-all, load extended mode, load mode, precharge-all, refresh, refresh, load mode. The cmd_op encoding is 0 for precharge-all, 1 for refresh, 2 for load mode and 3 for load extended mode. Without fast mode, the first command is valid in the cycle after start is sampled.
- R3: fast_mode is captured when start is accepted and later changes are ignored. The extended mode argument is 0 (fast) or 1 (slow). The first mode load argument is 0x161 (fast) or 0x21 (slow). The final mode load argument is 0x61 (fast) or 0x21 (slow). Precharge and refresh carry argument 0.
- R4: In fast mode, dll_locked is sampled once every POLL_CYCLES (default 4) cycles, with the first sample POLL_CYCLES cycles after start is taken. The first command becomes valid in the cycle after the sample that sees lock.
- R5: If DLL_POLLS (default 100) samples all miss lock, error rises in the cycle after the last sample and no command is ever issued.
- R6: cmd_valid, cmd_op and cmd_arg hold steady until cmd_done. A done seen in any of the first CMD_TIMEOUT (default 16) cycles of a command ends it, and the next command is valid in the following cycle.
- R7: If a command gets no done within CMD_TIMEOUT cycles, error rises and cmd_valid drops. The block then stays in the error state (step 11) and ignores start until reset.
- R8: When the final mode load completes, refresh_en and clear_req rise together. clear_req holds until clear_done, and if clear_done does not arrive within CLEAR_TIMEOUT (default 64) cycles the block enters the error state.
- R9: ready rises only in the cycle after clear_done is accepted. It then stays high with refresh_en high, and start is ignored.
- R10: step reads 0 idle, 1 lock wait, 2+k while command k (0..6) is active, 9 memory clear, 10 ready, 11 error.
- R11: cmd_done and clear_done have no effect while the block is not waiting for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the sequence from idle |
| fast_mode | input | 1 | Strap: fast mode (lock wait, fast mode values) |
| dll_locked | input | 1 | Strobe DLL lock indication |
| cmd_valid | output | 1 | Command pending (busy) |
| cmd_op | output | 2 | Command opcode |
| cmd_arg | output | 13 | Mode register value for load commands |
| cmd_done | input | 1 | Completion pulse for the pending command |
| refresh_en | output | 1 | Periodic refresh enabled |
| clear_req | output | 1 | Memory-clear request |
| clear_done | input | 1 | Memory-clear completion pulse |
| ready | output | 1 | Normal accesses allowed |
| error | output | 1 | Sequence aborted on a timeout |
| step | output | 4 | Current step code |

## Verification
A wrong step index shows at the command port in the same cycle: the opcode or argument no longer matches the expected entry for that position, and the step code is off. A broken timeout counter shows as an error rising one cycle too early or too late against the exact limit, so the bench drives done on the last allowed cycle and one cycle past it. A fault in the lock poller shows as the first command appearing off the poll grid, and the bench measures that to the cycle. A stray done in the wrong phase shows as a step change in the cycle after the pulse.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int unsigned ARG_W   = 13;
    localparam int unsigned STEP_W  = 4;
    localparam int unsigned N_CMDS  = 7;
    localparam int unsigned IDX_W   = $clog2(N_CMDS);

    localparam logic [STEP_W-1:0] STEP_IDLE  = 4'd0;
    localparam logic [STEP_W-1:0] STEP_LOCK  = 4'd1;
    localparam logic [STEP_W-1:0] STEP_CMD0  = 4'd2;
    localparam logic [STEP_W-1:0] STEP_CLEAR = 4'd9;
    localparam logic [STEP_W-1:0] STEP_READY = 4'd10;
    localparam logic [STEP_W-1:0] STEP_FAIL  = 4'd11;

    typedef enum logic [1:0] {
        OP_PRECHARGE = 2'd0,
        OP_REFRESH   = 2'd1,
        OP_LOAD_MODE = 2'd2,
        OP_LOAD_EXT  = 2'd3
    } sdram_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOCK,
        PH_CMD,
        PH_CLEAR,
        PH_READY,
        PH_FAIL
    } phase_e;

    typedef struct packed {
        sdram_op_e        op;
        logic [ARG_W-1:0] arg;
    } sdram_cmd_t;

    // Command table: position in the sequence and strap select opcode and value.
    function automatic sdram_cmd_t step_cmd(input logic [IDX_W-1:0] idx, input logic fast);
        sdram_cmd_t c;
        c.op  = OP_PRECHARGE;
        c.arg = '0;
        case (idx)
            3'd1: begin
                c.op  = OP_LOAD_EXT;
                c.arg = fast ? 13'h000 : 13'h001;
            end
            3'd2: begin
                c.op  = OP_LOAD_MODE;
                c.arg = fast ? 13'h161 : 13'h021;
            end
            3'd4, 3'd5: c.op = OP_REFRESH;
            3'd6: begin
                c.op  = OP_LOAD_MODE;
                c.arg = fast ? 13'h061 : 13'h021;
            end
            default: c.op = OP_PRECHARGE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/init_cycle_timer.sv
module init_cycle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/init_dll_poller.sv
module init_dll_poller #(
    parameter int unsigned POLL_CYCLES = 4,
    parameter int unsigned DLL_POLLS   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic dll_locked,
    output logic lock_seen,
    output logic give_up
);
    localparam int unsigned TW = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
    localparam int unsigned PW = (DLL_POLLS > 2) ? $clog2(DLL_POLLS) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(POLL_CYCLES - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(DLL_POLLS - 1);

    logic [TW-1:0] tick_q;
    logic [PW-1:0] polls_q;
    logic          poll_now;

    assign poll_now  = enable && (tick_q == TICK_LAST);
    assign lock_seen = poll_now && dll_locked;
    assign give_up   = poll_now && !dll_locked && (polls_q == POLL_LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else begin
            tick_q <= poll_now ? '0 : tick_q + 1'b1;
            if (poll_now && !dll_locked && !give_up) begin
                polls_q <= polls_q + 1'b1;
            end
        end
    end

    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        enable |-> (int'(polls_q) < DLL_POLLS)); // R5

endmodule

// File: rtl/init_cmd_table.sv
module init_cmd_table
    import sdram_init_pkg::*;
(
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    input  logic             fast,
    output logic [1:0]       op,
    output logic [ARG_W-1:0] arg
);
    sdram_cmd_t entry;

    always_comb begin
        entry = step_cmd(idx, fast);
        if (active) begin
            op  = entry.op;
            arg = entry.arg;
        end else begin
            op  = '0;
            arg = '0;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CMD_TIMEOUT   = 16,
    parameter int unsigned CLEAR_TIMEOUT = 64,
    parameter int unsigned POLL_CYCLES   = 4,
    parameter int unsigned DLL_POLLS     = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fast_mode,
    input  logic             dll_locked,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_done,
    output logic             refresh_en,
    output logic             clear_req,
    input  logic             clear_done,
    output logic             ready,
    output logic             error,
    output logic [STEP_W-1:0] step
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CMDS - 1);

    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             fast_q, fast_d;
    logic             restart;
    logic             lock_seen, lock_give_up;
    logic             cmd_expired, clear_expired;

    init_dll_poller #(
        .POLL_CYCLES(POLL_CYCLES),
        .DLL_POLLS  (DLL_POLLS)
    ) u_poller (
        .clk       (clk),
        .rst       (rst),
        .enable    (phase_q == PH_LOCK),
        .dll_locked(dll_locked),
        .lock_seen (lock_seen),
        .give_up   (lock_give_up)
    );

    init_cycle_timer #(.LIMIT(CMD_TIMEOUT)) u_cmd_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .run    (phase_q == PH_CMD),
        .expired(cmd_expired)
    );

    init_cycle_timer #(.LIMIT(CLEAR_TIMEOUT)) u_clear_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .run    (phase_q == PH_CLEAR),
        .expired(clear_expired)
    );

    init_cmd_table u_table (
        .active(phase_q == PH_CMD),
        .idx   (idx_q),
        .fast  (fast_q),
        .op    (cmd_op),
        .arg   (cmd_arg)
    );

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        fast_d  = fast_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    fast_d  = fast_mode;
                    idx_d   = '0;
                    phase_d = fast_mode ? PH_LOCK : PH_CMD;
                end
            end
            PH_LOCK: begin
                if (lock_seen) begin
                    phase_d = PH_CMD;
                end else if (lock_give_up) begin
                    phase_d = PH_FAIL;
                end
            end
            PH_CMD: begin
                if (cmd_done) begin
                    if (idx_q == LAST_IDX) begin
                        phase_d = PH_CLEAR;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else if (cmd_expired) begin
                    phase_d = PH_FAIL;
                end
            end
            PH_CLEAR: begin
                if (clear_done) begin
                    phase_d = PH_READY;
                end else if (clear_expired) begin
                    phase_d = PH_FAIL;
                end
            end
            PH_READY: phase_d = PH_READY;
            PH_FAIL:  phase_d = PH_FAIL;
            default:  phase_d = PH_FAIL;
        endcase
    end

    assign restart = (phase_d != phase_q) || (idx_d != idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            fast_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            fast_q  <= fast_d;
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_IDLE:  step = STEP_IDLE;
            PH_LOCK:  step = STEP_LOCK;
            PH_CMD:   step = STEP_CMD0 + STEP_W'(idx_q);
            PH_CLEAR: step = STEP_CLEAR;
            PH_READY: step = STEP_READY;
            default:  step = STEP_FAIL;
        endcase
    end

    assign cmd_valid  = (phase_q == PH_CMD);
    assign clear_req  = (phase_q == PH_CLEAR);
    assign refresh_en = (phase_q == PH_CLEAR) || (phase_q == PH_READY);
    assign ready      = (phase_q == PH_READY);
    assign error      = (phase_q == PH_FAIL);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_IDLE) |-> (!cmd_valid && !refresh_en && !ready)); // R1

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> ((cmd_valid && $stable(cmd_op) && $stable(cmd_arg)) || error)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        error |=> (error && !cmd_valid)); // R7

    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, clear_req, ready, error})); // R8

    AST_READY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(clear_req) && $past(clear_done))); // R9

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> (ready && refresh_en)); // R9

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

    localparam int CMD_TO   = 16;
    localparam int CLR_TO   = 64;
    localparam int POLL     = 4;
    localparam int NPOLLS   = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        fast_mode = 1'b0;
    logic        dll_locked = 1'b0;
    logic        cmd_done = 1'b0;
    logic        clear_done = 1'b0;
    logic        cmd_valid, refresh_en, clear_req, ready, error;
    logic [1:0]  cmd_op;
    logic [12:0] cmd_arg;
    logic [3:0]  step;

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sdram_init_seq dut (
        .clk(clk), .rst(rst), .start(start), .fast_mode(fast_mode),
        .dll_locked(dll_locked), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_done(cmd_done), .refresh_en(refresh_en),
        .clear_req(clear_req), .clear_done(clear_done), .ready(ready),
        .error(error), .step(step)
    );

    function automatic logic [1:0] exp_op(input int i);
        if (i == 1) return 2'd3;
        if (i == 2 || i == 6) return 2'd2;
        if (i == 4 || i == 5) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [12:0] exp_arg(input int i, input bit f);
        if (i == 1) return f ? 13'h0 : 13'h1;
        if (i == 2) return f ? 13'h161 : 13'h21;
        if (i == 6) return f ? 13'h61 : 13'h21;
        return 13'h0;
    endfunction

    function automatic int exp_lock_wait(input int k);
        return POLL * ((k + 1 + POLL - 1) / POLL);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 0; cmd_done = 0; clear_done = 0; dll_locked = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    // Launch; returns at the negedge where the first command is visible (or lock timeout).
    task automatic launch(input bit f, input int k, output bit ok);
        int n;
        ok = 1;
        start = 1'b1; fast_mode = f;
        tick();
        start = 1'b0;
        fast_mode = 1'($urandom % 2);   // R3: later strap changes ignored
        if (!f) begin
            chk(cmd_valid === 1'b1, "R2 first cmd after start", 32'(cmd_valid), 1);
        end else begin
            n = 0;
            while (!cmd_valid && !error && n < 1000) begin
                if (n == k) dll_locked = 1'b1;
                if (n == 1) chk(step == 4'd1, "R10 lock wait step", 32'(step), 1);
                tick();
                n++;
            end
            chk(n == exp_lock_wait(k), "R4 first cmd on poll grid", 32'(n), 32'(exp_lock_wait(k)));
        end
    endtask

    task automatic drive_cmds(input bit f, input int bad_idx, input int bad_delay, output bit failed);
        int d;
        failed = 0;
        for (int i = 0; i < 7; i++) begin
            chk(cmd_valid === 1'b1, "R6 next cmd valid", 32'(cmd_valid), 1);
            chk(cmd_op == exp_op(i), "R2 opcode order", 32'(cmd_op), 32'(exp_op(i)));
            chk(cmd_arg == exp_arg(i, f), "R3 argument", 32'(cmd_arg), 32'(exp_arg(i, f)));
            chk(step == 4'(2 + i), "R10 cmd step", 32'(step), 32'(2 + i));
            chk(ready == 1'b0 && refresh_en == 1'b0, "R9 no ready early", 32'({ready, refresh_en}), 0);
            d = (i == bad_idx) ? bad_delay : int'($urandom % CMD_TO);
            repeat (d) tick();
            if (d >= CMD_TO) begin
                chk(error == 1'b1 && cmd_valid == 1'b0, "R7 cmd timeout", 32'({error, cmd_valid}), 2);
                failed = 1;
                return;
            end
            chk(cmd_valid && cmd_op == exp_op(i), "R6 cmd held", 32'(cmd_op), 32'(exp_op(i)));
            cmd_done = 1'b1;
            tick();
            cmd_done = 1'b0;
        end
        chk(clear_req && refresh_en && !cmd_valid, "R8 clear and refresh on", 32'({clear_req, refresh_en, cmd_valid}), 6);
        chk(step == 4'd9, "R10 clear step", 32'(step), 9);
    endtask

    task automatic finish_clear(input int cd);
        repeat (cd) tick();
        if (cd >= CLR_TO) begin
            chk(error == 1'b1 && !clear_req, "R8 clear timeout", 32'({error, clear_req}), 2);
            return;
        end
        chk(!ready && clear_req, "R9 ready waits for clear", 32'({ready, clear_req}), 1);
        clear_done = 1'b1;
        tick();
        clear_done = 1'b0;
        chk(ready && refresh_en && !clear_req, "R9 ready after clear", 32'({ready, refresh_en, clear_req}), 6);
        chk(step == 4'd10, "R10 ready step", 32'(step), 10);
    endtask

    task automatic full_run(input bit f, input int k, input int bad_idx, input int bad_delay, input int cd);
        bit ok, failed;
        do_reset();
        launch(f, k, ok);
        drive_cmds(f, bad_idx, bad_delay, failed);
        if (!failed) finish_clear(cd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        bit ok, failed;
        void'($urandom(32'h5eed));

        // R1: reset state
        tick();
        chk(!cmd_valid && !refresh_en && !clear_req && !ready && !error, "R1 outputs in reset",
            32'({cmd_valid, refresh_en, clear_req, ready, error}), 0);
        do_reset();
        chk(step == 4'd0 && !cmd_valid, "R1 idle after reset", 32'(step), 0);

        // R11: stray done pulses in idle
        cmd_done = 1; clear_done = 1; repeat (3) tick(); cmd_done = 0; clear_done = 0; tick();
        chk(step == 4'd0 && !cmd_valid && !ready, "R11 stray done in idle", 32'(step), 0);

        // Directed slow and fast full runs
        full_run(1'b0, 0, -1, 0, 5);
        full_run(1'b1, 3, -1, 0, 0);
        full_run(1'b1, 4, -1, 0, 63);      // R8 last allowed clear cycle
        full_run(1'b0, 0, 3, CMD_TO - 1, 1); // R6 done on last allowed cycle

        // R9: start ignored once ready
        start = 1; tick(); start = 0; tick();
        chk(step == 4'd10 && ready && !cmd_valid, "R9 start ignored when ready", 32'(step), 10);

        // R7: command timeout, then sticky
        full_run(1'b0, 0, 4, CMD_TO, 0);
        start = 1; tick(); start = 0; repeat (3) tick();
        chk(step == 4'd11 && error && !cmd_valid, "R7 error held, start ignored", 32'(step), 11);

        // R8: clear timeout
        full_run(1'b1, 10, -1, 0, CLR_TO);
        chk(step == 4'd11, "R8 error step after clear timeout", 32'(step), 11);

        // R5: lock never seen
        do_reset();
        start = 1; fast_mode = 1; tick(); start = 0;
        cmd_done = 1;  // R11: stray done during lock wait
        for (int n = 0; n < POLL * NPOLLS - 1; n++) begin
            if (cmd_valid || error) break;
            tick();
        end
        cmd_done = 0;
        chk(!error && !cmd_valid && step == 4'd1, "R5 no error before last poll", 32'({error, cmd_valid}), 0);
        tick();
        chk(error && !cmd_valid, "R5 lock timeout error", 32'({error, cmd_valid}), 2);

        // Random runs
        for (int r = 0; r < 12; r++) begin
            full_run(1'($urandom % 2), int'($urandom % 40), -1, 0, int'($urandom % CLR_TO));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule